// File: doc/BRIEF.md
# Tag Check Fault Mode Controller

This block decides what happens after a memory tag check has failed. For each reported failure it receives the failing address, whether the access was a store, the kind of translation regime in use (the unprivileged regime or a higher one, and whether the regime splits the address space into two ranges), the exception level that owns the status register, and the system control word. The control word holds one 2-bit response mode for the unprivileged regime and another for all higher regimes.

The block responds in one of three ways, depending on the selected mode and the access direction. It can ignore the failure. It can raise a one-cycle synchronous abort pulse, which carries a fixed fault status code and the failing address. Or it can set a sticky bit in a small per-exception-level fault-status register. Software clears those bits through a clear port. A single pending output summarises all status bits, so it can serve as an interrupt-style request.

Top module: `tag_fault_router`

## Requirements
- R1: The mode is taken from control bits 39:38 when `regime_el0` is 1, and from control bits 41:40 otherwise. The bits of the unselected field have no effect.
- R2: Mode 0 ignores a failure: no abort pulse and no change to any status bit.
- R3: In mode 1, a failure presented at a clock edge makes `sync_abort` high for exactly the following cycle. `sync_addr` then equals the failing address and `sync_syndrome[5:0]` equals 0x11. Both syndrome and address hold their values until the next abort.
- R4: The syndrome places the store flag in bit 6 and the "current exception level is nonzero" flag in bit 7.
- R5: Mode 2 sets one bit in the status register of the exception level given by `target_el` and raises no abort. `status` packs level n into bits [2n+1:2n].
- R6: The status bit index is failing-address bit 55 when `two_ranges` is 1 and 0 otherwise. Bits are ORed in and stay set until cleared.
- R7: Mode 3 handles a store like mode 2 and a load like mode 1.
- R8: A clear request with `clr_el` and `clr_mask` clears the masked bits of that level at the next edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: `async_pending` is 1 whenever any status bit of any level is 1.
- R10: After reset, `sync_abort`, `sync_syndrome`, `sync_addr`, `status` and `async_pending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_valid | input | 1 | A tag check failure is reported this cycle |
| fail_addr | input | ADDR_W | Failing virtual address |
| fail_is_write | input | 1 | 1 for a store, 0 for a load |
| regime_el0 | input | 1 | The failure occurred in the unprivileged regime |
| two_ranges | input | 1 | The regime has two address ranges |
| cur_el_nz | input | 1 | The current exception level is nonzero |
| target_el | input | EL_W | Level whose status register takes asynchronous faults |
| ctl_word | input | CTL_W | System control word that holds both mode fields |
| clr_valid | input | 1 | Software clear request |
| clr_el | input | EL_W | Level to clear |
| clr_mask | input | 2 | Status bits to clear |
| sync_abort | output | 1 | One-cycle synchronous abort pulse |
| sync_syndrome | output | 8 | Abort syndrome: {el_nz, write, fsc[5:0]} |
| sync_addr | output | ADDR_W | Address that raised the last abort |
| status | output | 2*NUM_EL | Fault-status registers of all levels |
| async_pending | output | 1 | OR of all status bits |

## Verification
The assertions assume that `fail_valid` and the other failure inputs are stable and settled at the sampling edge, and that `target_el` and `clr_el` name a level below NUM_EL. The stickiness and rise checks assume that a status bit changes only through the set path or the clear port. The directed stimulus drives every input on the falling edge. It uses only levels 0 to 3 and presents each failure for a single cycle. This keeps every abort attributable to the failure one edge earlier.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
    typedef enum logic [1:0] {
        FM_IGNORE = 2'd0,
        FM_SYNC   = 2'd1,
        FM_ASYNC  = 2'd2,
        FM_SPLIT  = 2'd3
    } fail_mode_e;

    localparam logic [5:0] TAG_FSC = 6'h11;

    typedef struct packed {
        logic       el_nz;
        logic       is_write;
        logic [5:0] fsc;
    } syndrome_t;
endpackage

// File: rtl/tfr_mode_decode.sv
module tfr_mode_decode
    import tfr_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int CTL_W       = 64,
    parameter int EL0_MODE_LO = 38,
    parameter int HI_MODE_LO  = 40,
    parameter int RANGE_BIT   = 55
) (
    input  logic              fail_valid,
    input  logic [ADDR_W-1:0] fail_addr,
    input  logic              fail_is_write,
    input  logic              regime_el0,
    input  logic              two_ranges,
    input  logic [CTL_W-1:0]  ctl_word,
    output logic              want_sync,
    output logic              want_async,
    output logic              async_bit
);
    fail_mode_e mode;
    logic       unused_bits;

    assign unused_bits = ^{ctl_word, fail_addr};

    always_comb begin
        mode = regime_el0 ? fail_mode_e'(ctl_word[EL0_MODE_LO +: 2])
                          : fail_mode_e'(ctl_word[HI_MODE_LO +: 2]);
        want_sync  = 1'b0;
        want_async = 1'b0;
        if (fail_valid) begin
            unique case (mode)
                FM_IGNORE: ;
                FM_SYNC:   want_sync  = 1'b1;
                FM_ASYNC:  want_async = 1'b1;
                FM_SPLIT: begin
                    want_async = fail_is_write;
                    want_sync  = !fail_is_write;
                end
                default: ;
            endcase
        end
        async_bit = two_ranges ? fail_addr[RANGE_BIT] : 1'b0;
    end

    // R7: never both responses for one failure
    always_comb begin
        a_one_response_r7: assert (!(want_sync && want_async));
    end
endmodule

// File: rtl/tfr_status_bank.sv
module tfr_status_bank #(
    parameter int NUM_EL = 4,
    localparam int EL_W  = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_valid,
    input  logic [EL_W-1:0]     set_el,
    input  logic                set_bit,
    input  logic                clr_valid,
    input  logic [EL_W-1:0]     clr_el,
    input  logic [1:0]          clr_mask,
    output logic [2*NUM_EL-1:0] status,
    output logic                any_set
);
    logic [NUM_EL-1:0][1:0] status_d, status_q;

    always_comb begin
        status_d = status_q;
        for (int e = 0; e < NUM_EL; e++) begin
            if (clr_valid && clr_el == EL_W'(e))
                status_d[e] = status_d[e] & ~clr_mask;
            if (set_valid && set_el == EL_W'(e))
                status_d[e][set_bit] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status  = status_q;
    assign any_set = |status_q;

    for (genvar e = 0; e < NUM_EL; e++) begin : g_el
        for (genvar b = 0; b < 2; b++) begin : g_bit
            // R6: a set bit survives unless its clear arrives
            p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
                status_q[e][b] && !(clr_valid && clr_el == EL_W'(e) && clr_mask[b])
                |=> status_q[e][b]);
            // R5: a bit only rises after a set aimed at it
            p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(status_q[e][b])
                |-> $past(set_valid && set_el == EL_W'(e) && set_bit == b[0]));
            // R8: a clear with no competing set empties the bit
            p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
                clr_valid && clr_el == EL_W'(e) && clr_mask[b]
                && !(set_valid && set_el == EL_W'(e) && set_bit == b[0])
                |=> !status_q[e][b]);
        end
    end
endmodule

// File: rtl/tag_fault_router.sv
module tag_fault_router
    import tfr_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int CTL_W       = 64,
    parameter int NUM_EL      = 4,
    parameter int EL0_MODE_LO = 38,
    parameter int HI_MODE_LO  = 40,
    parameter int RANGE_BIT   = 55,
    localparam int EL_W       = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fail_valid,
    input  logic [ADDR_W-1:0]   fail_addr,
    input  logic                fail_is_write,
    input  logic                regime_el0,
    input  logic                two_ranges,
    input  logic                cur_el_nz,
    input  logic [EL_W-1:0]     target_el,
    input  logic [CTL_W-1:0]    ctl_word,
    input  logic                clr_valid,
    input  logic [EL_W-1:0]     clr_el,
    input  logic [1:0]          clr_mask,
    output logic                sync_abort,
    output logic [7:0]          sync_syndrome,
    output logic [ADDR_W-1:0]   sync_addr,
    output logic [2*NUM_EL-1:0] status,
    output logic                async_pending
);
    typedef struct packed {
        logic              abort;
        syndrome_t         syn;
        logic [ADDR_W-1:0] addr;
    } abort_state_t;

    abort_state_t st_d, st_q;
    logic want_sync, want_async, async_bit;

    tfr_mode_decode #(
        .ADDR_W(ADDR_W), .CTL_W(CTL_W), .EL0_MODE_LO(EL0_MODE_LO),
        .HI_MODE_LO(HI_MODE_LO), .RANGE_BIT(RANGE_BIT)
    ) i_decode (
        .fail_valid(fail_valid), .fail_addr(fail_addr),
        .fail_is_write(fail_is_write), .regime_el0(regime_el0),
        .two_ranges(two_ranges), .ctl_word(ctl_word),
        .want_sync(want_sync), .want_async(want_async), .async_bit(async_bit)
    );

    tfr_status_bank #(.NUM_EL(NUM_EL)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .set_valid(want_async), .set_el(target_el), .set_bit(async_bit),
        .clr_valid(clr_valid), .clr_el(clr_el), .clr_mask(clr_mask),
        .status(status), .any_set(async_pending)
    );

    always_comb begin
        st_d       = st_q;
        st_d.abort = want_sync;
        if (want_sync) begin
            st_d.syn.el_nz    = cur_el_nz;
            st_d.syn.is_write = fail_is_write;
            st_d.syn.fsc      = TAG_FSC;
            st_d.addr         = fail_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_abort    = st_q.abort;
    assign sync_syndrome = st_q.syn;
    assign sync_addr     = st_q.addr;

    // R3: an abort pulse always follows a reported failure
    p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_abort |-> $past(fail_valid));
    // R3: the abort carries the address of that failure
    p_abort_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_abort |-> sync_addr == $past(fail_addr));
    // R4: the syndrome write flag matches the failing access
    p_abort_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_abort |-> sync_syndrome[6] == $past(fail_is_write));
    // R3: without an abort the captured values hold
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_abort |-> $stable(sync_addr) && $stable(sync_syndrome));
endmodule

// File: tb/test_tag_fault_router.sv
module test_tag_fault_router;
    localparam int ADDR_W = 64;
    localparam int NUM_EL = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              fail_valid, fail_is_write, regime_el0, two_ranges, cur_el_nz;
    logic [ADDR_W-1:0] fail_addr;
    logic [1:0]        target_el, clr_el, clr_mask;
    logic [63:0]       ctl_word;
    logic              clr_valid;
    logic              sync_abort, async_pending;
    logic [7:0]        sync_syndrome;
    logic [ADDR_W-1:0] sync_addr;
    logic [7:0]        status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tag_fault_router i_tag_fault_router (
        .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_addr(fail_addr),
        .fail_is_write(fail_is_write), .regime_el0(regime_el0),
        .two_ranges(two_ranges), .cur_el_nz(cur_el_nz), .target_el(target_el),
        .ctl_word(ctl_word), .clr_valid(clr_valid), .clr_el(clr_el),
        .clr_mask(clr_mask), .sync_abort(sync_abort),
        .sync_syndrome(sync_syndrome), .sync_addr(sync_addr),
        .status(status), .async_pending(async_pending)
    );

    function automatic logic [63:0] mk_ctl(input logic [1:0] el0_mode,
                                           input logic [1:0] hi_mode);
        logic [63:0] c = 64'hFFFF_F0FF_FFFF_FFFF & ~(64'hF << 38);
        c[39:38] = el0_mode;
        c[41:40] = hi_mode;
        return c;
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fail_valid = 0; fail_is_write = 0; regime_el0 = 0; two_ranges = 0;
        cur_el_nz = 0; fail_addr = '0; target_el = 0; ctl_word = '0;
        clr_valid = 0; clr_el = 0; clr_mask = 0;
    endtask

    // Drive on the falling edge, then sample 1 ns after the next rising edge.
    task automatic fail_step(input logic el0, input logic [63:0] ctl,
                             input logic wr, input logic nz, input logic tr,
                             input logic [1:0] tel, input logic [63:0] addr);
        @(negedge clk);
        idle_inputs();
        fail_valid = 1; regime_el0 = el0; ctl_word = ctl; fail_is_write = wr;
        cur_el_nz = nz; two_ranges = tr; target_el = tel; fail_addr = addr;
        @(posedge clk); #1;
    endtask

    task automatic clear_step(input logic [1:0] el, input logic [1:0] mask);
        @(negedge clk);
        idle_inputs();
        clr_valid = 1; clr_el = el; clr_mask = mask;
        @(posedge clk); #1;
    endtask

    task automatic quiet_step();
        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check("R10 abort", sync_abort, 0);
        check("R10 syndrome", sync_syndrome, 0);
        check("R10 addr", sync_addr, 0);
        check("R10 status", status, 0);
        check("R10 pending", async_pending, 0);
    endtask

    task automatic t_mode_select();
        // unprivileged regime, its field 0, higher field 1 -> ignored
        fail_step(1, mk_ctl(2'd0, 2'd1), 1, 1, 1, 2'd3, 64'h00FF_0000_0000_0040);
        check("R1 R2 el0 field 0 no abort", sync_abort, 0);
        check("R2 mode0 status untouched", status, 0);
        // unprivileged regime, its field 1, higher field 0 -> abort
        fail_step(1, mk_ctl(2'd1, 2'd0), 0, 0, 0, 2'd0, 64'h1000);
        check("R1 el0 field 1 abort", sync_abort, 1);
        // higher regime, higher field 0 -> ignored
        fail_step(0, mk_ctl(2'd1, 2'd0), 0, 1, 0, 2'd1, 64'h2000);
        check("R1 R2 hi field 0 no abort", sync_abort, 0);
        check("R2 hi mode0 status", status, 0);
    endtask

    task automatic t_sync();
        fail_step(0, mk_ctl(2'd0, 2'd1), 1, 1, 0, 2'd0, 64'h0123_4567_89AB_CDE0);
        check("R3 abort pulse", sync_abort, 1);
        check("R3 abort addr", sync_addr, 64'h0123_4567_89AB_CDE0);
        check("R3 R4 syndrome wr nz", sync_syndrome, 8'hD1);
        check("R3 sync leaves status", status, 0);
        quiet_step();
        check("R3 pulse one cycle", sync_abort, 0);
        check("R3 addr held", sync_addr, 64'h0123_4567_89AB_CDE0);
    endtask

    task automatic t_async();
        fail_step(0, mk_ctl(2'd0, 2'd2), 0, 1, 1, 2'd2, 64'h0080_0000_0000_1000);
        check("R5 R6 bit55 set el2 bit1", status, 8'h20);
        check("R5 no abort", sync_abort, 0);
        check("R9 pending", async_pending, 1);
        fail_step(0, mk_ctl(2'd0, 2'd2), 0, 1, 0, 2'd2, 64'h0080_0000_0000_1000);
        check("R6 single range bit0 sticky", status, 8'h30);
    endtask

    task automatic t_split();
        fail_step(0, mk_ctl(2'd0, 2'd3), 1, 1, 0, 2'd1, 64'h3000);
        check("R7 store async el1", status, 8'h34);
        check("R7 store no abort", sync_abort, 0);
        fail_step(0, mk_ctl(2'd0, 2'd3), 0, 0, 0, 2'd1, 64'h4010);
        check("R7 load abort", sync_abort, 1);
        check("R4 load syndrome", sync_syndrome, 8'h11);
        check("R7 load addr", sync_addr, 64'h4010);
        check("R7 load status unchanged", status, 8'h34);
    endtask

    task automatic t_clear();
        clear_step(2'd2, 2'b01);
        check("R8 clear el2 bit0", status, 8'h24);
        // clear el1 both bits while a set hits el1 bit0 -> set wins on bit0
        @(negedge clk);
        idle_inputs();
        fail_valid = 1; ctl_word = mk_ctl(2'd0, 2'd2); target_el = 2'd1;
        clr_valid = 1; clr_el = 2'd1; clr_mask = 2'b11;
        @(posedge clk); #1;
        check("R8 set beats clear", status, 8'h24);
        clear_step(2'd1, 2'b11);
        check("R8 clear el1", status, 8'h20);
        check("R9 pending still", async_pending, 1);
        clear_step(2'd2, 2'b11);
        check("R8 clear el2", status, 8'h00);
        check("R9 pending low", async_pending, 0);
    endtask

    initial begin
        t_reset();
        t_mode_select();
        t_sync();
        t_async();
        t_split();
        t_clear();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule